// File: doc/BRIEF.md
# LCD Palette and Frame Load Sequencer

This block is the fetch-control front end of a raster LCD controller. Software programs a control word that carries an enable bit, a two-bit load-mode field and one interrupt-enable bit per status flag. Once enabled, the block consumes a 16-bit word stream from a DMA-style source. Depending on the mode, it first fills a 12-bit colour lookup table, then passes pixel words through to the pixel path, or it does both in turn.

The first palette word also carries the pixel-depth code in its top nibble, and that code sets how many table entries are loaded. Turning the block off does not cut the output short. The frame in flight is allowed to finish, and only then does the block go idle and raise a completion flag. That flag stays up until the next enable. Error events (FIFO underflow, sync loss) and timing events (vertical sync, AC-bias count, line interrupt) are recorded in a sticky status vector that drives one interrupt line.

Top module: `lcd_load_seq`

## Requirements
- R1: After reset, the status vector is 0, `irq` is 0, `in_ready` is 0, `pix_valid` is 0 and `bpp_code` is 0.
- R2: A control write with bit 0 set from idle starts a run in the mode given by bits [21:20]. Modes 0 (palette then frames) and 1 (palette only) begin with a palette load. In that load, accepted word k writes its bits [11:0] (red [11:8], green [7:4], blue [3:0]) into table entry k, and word 0 bits [15:12] become `bpp_code`.
- R3: The palette is 16 entries when the word-0 code is 4 or above (4 = 12/16 bpp), and 256 entries for codes 0 to 3. Entries beyond that length keep their contents. Status bit 1 (palette loaded) rises on the clock edge that accepts the last entry.
- R4: In mode 1, once the last entry is written, `in_ready` drops. All further input is ignored (no table write, no `pix_valid`) until a disable.
- R5: In the frame phase (after the palette in mode 0, or immediately in modes 2 and 3), `in_ready` is 1 and `pix_valid`/`pix_data` follow `in_valid`/`in_data` in the same cycle.
- R6: A control write with bit 0 clear during the frame phase keeps the pass-through running until a `frame_end` pulse. A `frame_end` in the same cycle as the write counts as that end. On the edge that ends the frame, the block goes idle and status bit 0 (done) is set. A disable during the palette phase, or after a mode-1 load, goes idle and sets done at once.
- R7: Done is unaffected by status writes and holds until a control write with bit 0 set, which clears it. An enable written while a disabled frame is still finishing cancels the disable, and no done is raised.
- R8: A status write clears, for each 1 in its data, bits 4 (vsync), 5 (AC-bias) and 6 (line) at any time, and bit 1 only when the current run's mode is 1. Writes never clear bits 0, 2 and 3.
- R9: While the block is not idle, `fuf_in`, `sync_lost_in`, `vsync_in`, `abc_in` and `line_in` set status bits 2, 3, 4, 5 and 6. In idle these inputs have no effect. A disable write clears bits 1, 2 and 3. An event in the same cycle as any clear wins.
- R10: `irq` is the OR over k of status bit k ANDed with control bit k+1, where control bits [7:1] are held from the latest control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control word: [0] enable, [7:1] interrupt enables, [21:20] load mode |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 7 | Write-one-to-clear mask for the status vector |
| in_valid | input | 1 | Source word valid |
| in_data | input | 16 | Source word |
| in_ready | output | 1 | Block accepts source words |
| frame_end | input | 1 | Pulse on the last word of a frame |
| fuf_in | input | 1 | Pixel FIFO underflow event |
| sync_lost_in | input | 1 | Sync loss event |
| vsync_in | input | 1 | Vertical sync event |
| abc_in | input | 1 | AC-bias count event |
| line_in | input | 1 | Line interrupt event |
| pix_valid | output | 1 | Pixel word valid toward the pixel path |
| pix_data | output | 16 | Pixel word |
| lut_rd_addr | input | 8 | Lookup table read address |
| lut_rd_data | output | 12 | Lookup table entry (combinational read) |
| bpp_code | output | 4 | Pixel-depth code from palette word 0 |
| sts | output | 7 | Status vector |
| irq | output | 1 | Interrupt request |

## Verification
The hardest collisions are an event input arriving in the same cycle as a clear of its status bit, and a disable write landing on the same edge as `frame_end`. The bench drives `vsync_in` together with a status write of bit 4, and `fuf_in` together with a disable write, and expects the bit to be set afterwards. It also issues a disable exactly on a `frame_end` pulse and expects done on that edge, with no extra frame of pass-through. A behavioural model follows every cycle and is compared against the ports, so each collision is judged both by a directed check and by the model's state.

// File: rtl/lcd_load_seq.sv
module lcd_load_seq #(
  parameter int DW        = 16,
  parameter int CW        = 12,
  parameter int LUT_N     = 256,
  parameter int LUT_SMALL = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_wr,
  input  logic [31:0]              ctl_wdata,
  input  logic                     sts_wr,
  input  logic [6:0]               sts_wdata,
  input  logic                     in_valid,
  input  logic [DW-1:0]            in_data,
  output logic                     in_ready,
  input  logic                     frame_end,
  input  logic                     fuf_in,
  input  logic                     sync_lost_in,
  input  logic                     vsync_in,
  input  logic                     abc_in,
  input  logic                     line_in,
  output logic                     pix_valid,
  output logic [DW-1:0]            pix_data,
  input  logic [$clog2(LUT_N)-1:0] lut_rd_addr,
  output logic [CW-1:0]            lut_rd_data,
  output logic [3:0]               bpp_code,
  output logic [6:0]               sts,
  output logic                     irq
);
  localparam int AW = $clog2(LUT_N);
  localparam int LW = AW + 1;

  typedef enum logic [2:0] {S_IDLE, S_PAL, S_HALT, S_FRAME, S_DRAIN} state_t;

  state_t        state;
  logic [1:0]    run_mode;
  logic [AW-1:0] pal_idx;
  logic [LW-1:0] pal_len;
  logic [6:0]    ctl_ie;
  logic [CW-1:0] lut [LUT_N];

  logic          wr_en, wr_dis, active, lut_we, pal_last, pal_set, done_set;
  logic [LW-1:0] pal_len_w;
  logic [6:0]    ev_set, sclr;
  logic          unused_ctl;

  assign unused_ctl = ^{ctl_wdata[31:22], ctl_wdata[19:8]};

  assign wr_en     = ctl_wr & ctl_wdata[0];
  assign wr_dis    = ctl_wr & ~ctl_wdata[0];
  assign active    = state != S_IDLE;
  assign in_ready  = (state == S_PAL) || (state == S_FRAME) || (state == S_DRAIN);
  assign pix_valid = in_valid && ((state == S_FRAME) || (state == S_DRAIN));
  assign pix_data  = in_data;

  assign pal_len_w = (pal_idx == '0)
                   ? ((in_data[DW-1 -: 4] >= 4'h4) ? LW'(LUT_SMALL) : LW'(LUT_N))
                   : pal_len;
  assign pal_last  = ({1'b0, pal_idx} == pal_len_w - LW'(1));
  assign lut_we    = (state == S_PAL) && in_valid && !wr_dis;
  assign pal_set   = lut_we && pal_last;

  always_comb begin
    done_set = 1'b0;
    case (state)
      S_PAL, S_HALT: done_set = wr_dis;
      S_FRAME:       done_set = wr_dis && frame_end;
      S_DRAIN:       done_set = !wr_en && frame_end;
      default:       done_set = 1'b0;
    endcase
  end

  assign ev_set = {active & line_in, active & abc_in, active & vsync_in,
                   active & sync_lost_in, active & fuf_in, pal_set, done_set};
  assign sclr   = (sts_wr ? (sts_wdata & {3'b111, 2'b00, run_mode == 2'd1, 1'b0}) : 7'b0)
                | (wr_dis ? 7'b0001110 : 7'b0)
                | {6'b0, wr_en};
  assign irq    = |(sts & ctl_ie);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      run_mode <= 2'd0;
      pal_idx  <= '0;
      pal_len  <= '0;
      bpp_code <= 4'h0;
      ctl_ie   <= '0;
      sts      <= '0;
    end else begin
      sts <= (sts & ~sclr) | ev_set;
      if (ctl_wr) ctl_ie <= ctl_wdata[7:1];
      case (state)
        S_IDLE:
          if (wr_en) begin
            run_mode <= ctl_wdata[21:20];
            pal_idx  <= '0;
            state    <= ctl_wdata[21] ? S_FRAME : S_PAL;
          end
        S_PAL:
          if (wr_dis) state <= S_IDLE;
          else if (in_valid) begin
            pal_idx <= pal_idx + AW'(1);
            pal_len <= pal_len_w;
            if (pal_idx == '0) bpp_code <= in_data[DW-1 -: 4];
            if (pal_last) state <= (run_mode == 2'd0) ? S_FRAME : S_HALT;
          end
        S_HALT:
          if (wr_dis) state <= S_IDLE;
        S_FRAME:
          if (wr_dis) state <= frame_end ? S_IDLE : S_DRAIN;
        S_DRAIN:
          if (wr_en) state <= S_FRAME;
          else if (frame_end) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (lut_we) lut[pal_idx] <= in_data[CW-1:0];
  end

  assign lut_rd_data = lut[lut_rd_addr];

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sts[0] && !(ctl_wr && ctl_wdata[0]) |=> sts[0]); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> !in_ready && !pix_valid); // R6

  AST_PAL_ONLY_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) && run_mode == 2'd1 |-> !in_ready); // R4

  AST_DIS_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_wdata[0] && !fuf_in && !sync_lost_in |=> !sts[2] && !sts[3]); // R9

  AST_PAL_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && sts_wdata[1] && run_mode == 2'd1 && !pal_set |=> !sts[1]); // R8
endmodule

// File: tb/tb_lcd_load_seq.sv
`timescale 1ns/100ps
module tb_lcd_load_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, sts_wr = 0, in_valid = 0, frame_end = 0;
  logic fuf_in = 0, sync_lost_in = 0, vsync_in = 0, abc_in = 0, line_in = 0;
  logic [31:0] ctl_wdata = 0;
  logic [6:0]  sts_wdata = 0;
  logic [15:0] in_data = 0;
  logic [7:0]  lut_rd_addr = 0;
  logic        in_ready, pix_valid, irq;
  logic [15:0] pix_data;
  logic [11:0] lut_rd_data;
  logic [3:0]  bpp_code;
  logic [6:0]  sts;

  always #2 clk = ~clk;

  lcd_load_seq dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .frame_end(frame_end), .fuf_in(fuf_in),
    .sync_lost_in(sync_lost_in), .vsync_in(vsync_in), .abc_in(abc_in), .line_in(line_in),
    .pix_valid(pix_valid), .pix_data(pix_data), .lut_rd_addr(lut_rd_addr),
    .lut_rd_data(lut_rd_data), .bpp_code(bpp_code), .sts(sts), .irq(irq));

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // behavioural reference: 0 idle, 1 palette, 2 halted, 3 frame, 4 finishing
  int mstate, mrun, midx, mlen;
  logic [6:0] msts, mie;
  logic [3:0] mbpp;
  logic [11:0] mlut [256];
  bit mvalid [256];

  always @(posedge clk) begin
    logic [6:0] s_set, s_clr;
    bit wen, wdis, act;
    if (!rst_n) begin
      mstate = 0; mrun = 0; midx = 0; mlen = 0; msts = 0; mie = 0; mbpp = 0;
    end else begin
      act = mstate != 0;
      wen = ctl_wr && ctl_wdata[0];
      wdis = ctl_wr && !ctl_wdata[0];
      s_set = 0; s_clr = 0;
      if (act) s_set[6:2] = {line_in, abc_in, vsync_in, sync_lost_in, fuf_in};
      if (sts_wr) s_clr = sts_wdata & {3'b111, 2'b00, mrun == 1, 1'b0};
      if (wdis) s_clr = s_clr | 7'b0001110;
      if (wen) s_clr[0] = 1;
      case (mstate)
        0: if (wen) begin mrun = int'(ctl_wdata[21:20]); midx = 0; mstate = (mrun < 2) ? 1 : 3; end
        1: if (wdis) begin mstate = 0; s_set[0] = 1; end
           else if (in_valid) begin
             if (midx == 0) begin mbpp = in_data[15:12]; mlen = (mbpp >= 4) ? 16 : 256; end
             mlut[midx] = in_data[11:0]; mvalid[midx] = 1;
             if (midx == mlen - 1) begin s_set[1] = 1; mstate = (mrun == 0) ? 3 : 2; end
             midx++;
           end
        2: if (wdis) begin mstate = 0; s_set[0] = 1; end
        3: if (wdis) begin
             if (frame_end) begin mstate = 0; s_set[0] = 1; end else mstate = 4;
           end
        4: if (wen) mstate = 3;
           else if (frame_end) begin mstate = 0; s_set[0] = 1; end
        default: mstate = 0;
      endcase
      msts = (msts & ~s_clr) | s_set;
      if (ctl_wr) mie = ctl_wdata[7:1];
    end
  end

  always @(negedge clk) begin
    bit er, ep;
    if (rst_n && !done_flag) begin
      er = (mstate == 1) || (mstate == 3) || (mstate == 4);
      ep = in_valid && ((mstate == 3) || (mstate == 4));
      chk(in_ready == er, "R4 model in_ready", in_ready, er);
      chk(pix_valid == ep && (!ep || pix_data == in_data), "R5 model pixel path", pix_valid, ep);
      chk(sts == msts, "R9 model status", sts, msts);
      chk(irq == |(msts & mie), "R10 model irq", irq, |(msts & mie));
      chk(bpp_code == mbpp, "R2 model bpp_code", bpp_code, mbpp);
    end
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  logic [6:0] ie_b = 0;

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic ctl(input bit en, input logic [1:0] mode);
    ctl_wr = 1; ctl_wdata = 0; ctl_wdata[0] = en; ctl_wdata[7:1] = ie_b; ctl_wdata[21:20] = mode;
    cyc(); ctl_wr = 0;
  endtask

  task automatic stsw(input logic [6:0] v);
    sts_wr = 1; sts_wdata = v; cyc(); sts_wr = 0;
  endtask

  task automatic word(input logic [15:0] d);
    in_valid = 1; in_data = d; cyc(); in_valid = 0;
  endtask

  function automatic logic [11:0] colr(input int j, input int seed);
    return 12'(j * 291 + seed * 77 + 17);
  endfunction

  task automatic load_pal(input int from, input int to, input logic [3:0] code, input int seed);
    for (int j = from; j < to; j++) begin
      if (j % 5 == 3) cyc();
      word({(j == 0) ? code : 4'(j * 7), colr(j, seed)});
    end
  endtask

  task automatic chk_lut(input int from, input int to, input int seed, input string tag);
    bit ok = 1;
    int bad = 0;
    for (int a = from; a < to; a++) begin
      lut_rd_addr = 8'(a); #0.2;
      if (lut_rd_data != colr(a, seed) && ok) begin ok = 0; bad = a; end
    end
    lut_rd_addr = 8'(bad); #0.2;
    chk(ok, tag, lut_rd_data, colr(bad, seed));
  endtask

  initial begin
    repeat (3) cyc();
    chk(sts == 0 && irq == 0 && in_ready == 0 && pix_valid == 0 && bpp_code == 0,
        "R1 reset state", sts, 0);
    rst_n = 1; cyc();

    // mode 1, 8 bpp code, 256 entries
    ctl(1, 2'd1);
    load_pal(0, 255, 4'h3, 1);
    chk(sts[1] == 0 && in_ready == 1, "R3 not loaded before last entry", sts[1], 0);
    word({4'h9, colr(255, 1)});
    chk(sts[1] == 1, "R3 loaded after entry 255", sts[1], 1);
    chk(bpp_code == 4'h3, "R2 bpp code from word 0", bpp_code, 3);
    chk(in_ready == 0, "R4 halted after palette-only load", in_ready, 0);
    in_valid = 1; in_data = 16'hFFFF; repeat (4) cyc(); in_valid = 0;
    chk(pix_valid == 0, "R4 no pixels while halted", pix_valid, 0);
    chk_lut(0, 256, 1, "R2 R4 table contents after extra input");
    stsw(7'h02);
    chk(sts[1] == 0, "R8 loaded bit clears in mode 1", sts[1], 0);
    ctl(0, 2'd1);
    chk(sts[0] == 1 && in_ready == 0, "R6 done on disable after halt", sts[0], 1);
    stsw(7'h7F);
    chk(sts[0] == 1, "R7 done ignores status write", sts[0], 1);

    // mode 0, 16 bpp code, 16 entries then frames
    ctl(1, 2'd0);
    chk(sts[0] == 0, "R7 enable clears done", sts[0], 0);
    load_pal(0, 16, 4'h4, 2);
    chk(sts[1] == 1 && bpp_code == 4'h4, "R3 short palette loaded", sts, 2);
    chk_lut(0, 16, 2, "R3 short palette entries");
    chk_lut(16, 256, 1, "R3 entries beyond short palette kept");
    in_valid = 1; in_data = 16'hA5C3; #0.5;
    chk(pix_valid == 1 && pix_data == 16'hA5C3 && in_ready == 1, "R5 pass-through after palette",
        pix_data, 16'hA5C3);
    cyc(); in_valid = 0;
    stsw(7'h02);
    chk(sts[1] == 1, "R8 loaded bit not write-clearable in mode 0", sts[1], 1);
    ctl(0, 2'd0);
    chk(in_ready == 1 && sts[0] == 0 && sts[1] == 0, "R6 R9 finishing frame after disable", sts, 0);
    word(16'h1234);
    repeat (3) cyc();
    frame_end = 1; cyc(); frame_end = 0;
    chk(sts[0] == 1 && in_ready == 0, "R6 done at frame end", sts[0], 1);
    fuf_in = 1; cyc(); fuf_in = 0;
    chk(sts[2] == 0, "R9 underflow ignored while idle", sts[2], 0);

    // mode 2 frames only, events
    ie_b = 7'h04;
    ctl(1, 2'd2);
    chk(sts[0] == 0 && in_ready == 1, "R5 frame mode ready at once", in_ready, 1);
    fuf_in = 1; cyc(); fuf_in = 0;
    chk(sts[2] == 1 && irq == 1, "R9 R10 underflow sets bit and irq", sts, 4);
    stsw(7'h0C);
    chk(sts[2] == 1, "R8 underflow not write-clearable", sts[2], 1);
    vsync_in = 1; sts_wr = 1; sts_wdata = 7'h10; cyc(); vsync_in = 0; sts_wr = 0;
    chk(sts[4] == 1, "R9 event beats same-cycle clear", sts[4], 1);
    line_in = 1; abc_in = 1; cyc(); line_in = 0; abc_in = 0;
    stsw(7'h70);
    chk(sts[6:4] == 3'b000, "R8 timing bits write-clear", sts[6:4], 0);
    ie_b = 7'h00;
    ctl(1, 2'd2);
    chk(irq == 0 && sts[2] == 1, "R10 irq masked", irq, 0);
    sync_lost_in = 1; cyc(); sync_lost_in = 0;
    ctl_wr = 1; ctl_wdata = 0; fuf_in = 1; cyc(); ctl_wr = 0; fuf_in = 0;
    chk(sts[2] == 1 && sts[3] == 0, "R9 event beats disable clear", sts[3:2], 1);
    ctl(1, 2'd2);
    chk(in_ready == 1, "R7 enable cancels pending disable", in_ready, 1);
    frame_end = 1; cyc(); frame_end = 0;
    chk(sts[0] == 0 && in_ready == 1, "R7 no done after cancel", sts[0], 0);
    ctl_wr = 1; ctl_wdata = 0; frame_end = 1; cyc(); ctl_wr = 0; frame_end = 0;
    chk(sts[0] == 1 && in_ready == 0 && sts[3:1] == 0, "R6 R9 disable on frame end", sts, 1);

    // disable during palette phase
    ctl(1, 2'd0);
    load_pal(0, 5, 4'h3, 3);
    ctl(0, 2'd0);
    chk(sts[0] == 1 && sts[1] == 0 && in_ready == 0, "R6 disable mid palette", sts, 1);
    chk_lut(0, 5, 3, "R2 partial palette written");
    repeat (4) cyc();
    finish_run();
  end
endmodule